// File: doc/BRIEF.md
# Memory-Window Serial Flash Access Sequencer

This block turns a single load or store aimed at a flash memory window into the byte sequence that a serial flash device expects. Each chip select owns its own 128 MiB window. The requester presents the chip select index, the byte offset inside that window, an access size of 1 to 8 bytes at any alignment, and write data for stores. The block lowers the chosen chip select. It then sends a command byte and the address bytes. On reads it adds a computed run of dummy transfers. It then moves the data and raises the chip select again.

Bits on the wire are moved by a separate byte-wide shift engine. The block hands that engine one byte at a time with a start pulse and waits for a done pulse, which carries the byte received in exchange. The read and write configuration words come in as plain inputs. A requester is held off through a ready signal while an access is in flight. A side flag warns when an access begins while software already holds a chip select low by hand.

Top module: `flash_window_seq`

## Requirements
- R1: After reset, and whenever no access is in flight, every chip select output is high, `busy` is low and `req_ready` is high.
- R2: From the cycle after acceptance, the selected chip select (index `req_cs`) alone is low, and it stays low until the last byte completes. `busy` is high and `req_ready` low during that whole span.
- R3: The first byte of every access is the command: bits 7:0 of `rd_cfg` for reads, bits 7:0 of `wr_cfg` for writes.
- R4: The address-size field is bits 17:16 of the configuration word in use. Value 0 sends offset bits 23:0 as three bytes, most significant first. Value 1 sends the zero-extended offset bits 31:0 as four bytes, most significant first. Values 2 and 3 send no address byte.
- R5: A read follows the address with (`rd_cfg`[13:12] × 8) >> `rd_cfg`[9:8] dummy transfers, each sending 0x00. A write sends none, whatever its configuration holds in those fields.
- R6: For a read, the k-th received data byte lands in `rsp_rdata` bits 8k+7:8k, starting at k = 0. Bytes beyond the access size read as zero. `rsp_valid` is high for exactly one cycle, with all chip selects already high.
- R7: For a write, `req_size` bytes of `req_wdata` are sent least significant byte first, directly after the address.
- R8: `conflict` pulses for one cycle, in the cycle after acceptance, when `user_cs_held` was high at acceptance. The access still runs in full.
- R9: `sh_start` lasts one cycle per byte, and `sh_tx` holds steady until `sh_done`. No new byte starts before the previous one is done. Every access sends exactly its command, address, dummy and data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cfg | input | 32 | Read configuration: command [7:0], access type [9:8], dummy bytes [13:12], address size [17:16] |
| wr_cfg | input | 32 | Write configuration: command [7:0], address size [17:16] |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cs | input | CS_IDX_W | Window / chip select index |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | SIZE_W | Bytes to move, 1 to DATA_BYTES |
| req_wdata | input | 8*DATA_BYTES | Store data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8*DATA_BYTES | Load data, little-endian |
| busy | output | 1 | Access in flight |
| user_cs_held | input | 1 | A software-driven chip select is currently low |
| conflict | output | 1 | Access accepted while a software chip select was held |
| cs_n | output | NUM_CS | Chip selects, active low |
| sh_start | output | 1 | Shift engine: send `sh_tx` |
| sh_tx | output | 8 | Byte to send |
| sh_done | input | 1 | Shift engine: byte finished |
| sh_rx | input | 8 | Byte received, valid with `sh_done` |

## Verification
On every cycle the assertions enforce the chip-select properties: at most one select is low, and none is low while idle or at the response strobe. They also check the shift handshake shape, meaning a single-cycle start, a byte that holds while in flight, and no start without a select. Both the acceptance stall and the one-cycle conflict pulse are checked too. Only the bench's scenarios can show that the byte stream itself is right. That covers command choice, each address-size code, the dummy count formula across access-type codes, dummies left out on writes, and the little-endian placement of read data. The bench checks these against sequences it predicts from the configuration words.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   // Dummy count reaches 24, so five bits cover every phase length.
   localparam int CNT_W = 5;

   // Bit positions inside the configuration words; the neighbours that
   // build these words depend on them.
   localparam int CMD_LSB  = 0;
   localparam int ACC_LSB  = 8;
   localparam int DBW_LSB  = 12;
   localparam int ASZ_LSB  = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_ISSUE,
      ST_WAIT,
      ST_REL
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_DATA
   } seq_phase_e;

   typedef struct packed {
      logic [2:0]       n_addr;
      logic [CNT_W-1:0] n_dummy;
   } seq_plan_t;

endpackage

// File: rtl/flash_seq_plan.sv
module flash_seq_plan
   import flash_seq_pkg::*;
(
   input  logic [31:0] cfg,
   input  logic        is_read,
   output seq_plan_t   plan
);

   logic [1:0]       asz;
   logic [1:0]       dbw;
   logic [1:0]       acc;
   logic [CNT_W-1:0] raw_dummy;

   always_comb begin
      asz       = cfg[ASZ_LSB +: 2];
      dbw       = cfg[DBW_LSB +: 2];
      acc       = cfg[ACC_LSB +: 2];
      raw_dummy = {dbw, 3'b000} >> acc;
      case (asz)
         2'd0:    plan.n_addr = 3'd3;
         2'd1:    plan.n_addr = 3'd4;
         default: plan.n_addr = 3'd0;
      endcase
      plan.n_dummy = is_read ? raw_dummy : '0;
   end

endmodule

// File: rtl/flash_seq_txsel.sv
module flash_seq_txsel
   import flash_seq_pkg::*;
#(
   parameter int DATA_BYTES = 8
)(
   input  seq_phase_e              phase,
   input  logic [CNT_W-1:0]        idx,
   input  logic [2:0]              n_addr,
   input  logic [7:0]              cmd,
   input  logic [31:0]             addr,
   input  logic [8*DATA_BYTES-1:0] wdata,
   input  logic                    is_write,
   output logic [7:0]              tx
);

   logic [2:0]              asel;
   logic [31:0]             ash;
   logic [8*DATA_BYTES-1:0] wsh;

   always_comb begin
      asel = n_addr - 3'd1 - idx[2:0];
      ash  = addr >> {asel[1:0], 3'b000};
      wsh  = wdata >> {idx, 3'b000};
      case (phase)
         PH_CMD:  tx = cmd;
         PH_ADDR: tx = ash[7:0];
         PH_DATA: tx = is_write ? wsh[7:0] : 8'h00;
         default: tx = 8'h00;
      endcase
   end

endmodule

// File: rtl/flash_seq_rxpack.sv
module flash_seq_rxpack #(
   parameter int DATA_BYTES = 8,
   parameter int IDX_W      = 5
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    capture,
   input  logic [IDX_W-1:0]        idx,
   input  logic [7:0]              rx,
   output logic [8*DATA_BYTES-1:0] data
);

   logic [7:0] lane_q [DATA_BYTES];

   for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[b] <= '0;
         else if (clear)
            lane_q[b] <= '0;
         else if (capture && idx == IDX_W'(b))
            lane_q[b] <= rx;
      end
      assign data[8*b +: 8] = lane_q[b];
   end

endmodule

// File: rtl/flash_window_seq.sv
module flash_window_seq
   import flash_seq_pkg::*;
#(
   parameter int  NUM_CS     = 2,
   parameter int  ADDR_W     = 27,
   parameter int  DATA_BYTES = 8,
   localparam int CS_IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int SIZE_W     = $clog2(DATA_BYTES + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [31:0]             rd_cfg,
   input  logic [31:0]             wr_cfg,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [CS_IDX_W-1:0]     req_cs,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [SIZE_W-1:0]       req_size,
   input  logic [8*DATA_BYTES-1:0] req_wdata,
   output logic                    rsp_valid,
   output logic [8*DATA_BYTES-1:0] rsp_rdata,
   output logic                    busy,
   input  logic                    user_cs_held,
   output logic                    conflict,
   output logic [NUM_CS-1:0]       cs_n,
   output logic                    sh_start,
   output logic [7:0]              sh_tx,
   input  logic                    sh_done,
   input  logic [7:0]              sh_rx
);

   if (NUM_CS < 1) begin : g_bad_cs
      $error("NUM_CS must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 1..32");
   end
   if (DATA_BYTES < 1 || DATA_BYTES > 8) begin : g_bad_data
      $error("DATA_BYTES must lie in 1..8");
   end

   seq_state_e              state_q;
   seq_phase_e              phase_q;
   seq_phase_e              nxt_ph;
   logic                    nxt_none;
   logic [CNT_W-1:0]        idx_q;
   logic [CNT_W-1:0]        ph_len;
   logic                    last;
   logic                    wr_q;
   logic [CS_IDX_W-1:0]     cs_q;
   logic [31:0]             addr_q;
   logic [SIZE_W-1:0]       size_q;
   logic [8*DATA_BYTES-1:0] wdata_q;
   logic [7:0]              cmd_q;
   logic [2:0]              n_addr_q;
   logic [CNT_W-1:0]        n_dummy_q;
   logic                    conflict_q;
   logic [31:0]             cfg_sel;
   seq_plan_t               plan;
   logic                    accept;
   logic                    sel_on;
   logic                    capture;

   assign cfg_sel = req_write ? wr_cfg : rd_cfg;
   assign accept  = (state_q == ST_IDLE) && req_valid;

   flash_seq_plan u_plan (
      .cfg     (cfg_sel),
      .is_read (!req_write),
      .plan    (plan)
   );

   always_comb begin
      case (phase_q)
         PH_CMD:   ph_len = CNT_W'(1);
         PH_ADDR:  ph_len = CNT_W'(n_addr_q);
         PH_DUMMY: ph_len = n_dummy_q;
         default:  ph_len = CNT_W'(size_q);
      endcase
      last = (idx_q + CNT_W'(1)) == ph_len;
   end

   always_comb begin
      nxt_ph   = PH_DATA;
      nxt_none = 1'b0;
      case (phase_q)
         PH_CMD: begin
            if (n_addr_q != 0)       nxt_ph = PH_ADDR;
            else if (n_dummy_q != 0) nxt_ph = PH_DUMMY;
            else if (size_q != 0)    nxt_ph = PH_DATA;
            else                     nxt_none = 1'b1;
         end
         PH_ADDR: begin
            if (n_dummy_q != 0)      nxt_ph = PH_DUMMY;
            else if (size_q != 0)    nxt_ph = PH_DATA;
            else                     nxt_none = 1'b1;
         end
         PH_DUMMY: begin
            if (size_q != 0)         nxt_ph = PH_DATA;
            else                     nxt_none = 1'b1;
         end
         default:                    nxt_none = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_CMD;
         idx_q      <= '0;
         wr_q       <= 1'b0;
         cs_q       <= '0;
         addr_q     <= '0;
         size_q     <= '0;
         wdata_q    <= '0;
         cmd_q      <= '0;
         n_addr_q   <= '0;
         n_dummy_q  <= '0;
         conflict_q <= 1'b0;
      end else begin
         conflict_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               wr_q       <= req_write;
               cs_q       <= req_cs;
               addr_q     <= 32'(req_addr);
               size_q     <= req_size;
               wdata_q    <= req_wdata;
               cmd_q      <= cfg_sel[CMD_LSB +: 8];
               n_addr_q   <= plan.n_addr;
               n_dummy_q  <= plan.n_dummy;
               conflict_q <= user_cs_held;
               state_q    <= ST_SEL;
            end
            ST_SEL: begin
               phase_q <= PH_CMD;
               idx_q   <= '0;
               state_q <= ST_ISSUE;
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: if (sh_done) begin
               if (!last) begin
                  idx_q   <= idx_q + CNT_W'(1);
                  state_q <= ST_ISSUE;
               end else if (nxt_none) begin
                  state_q <= ST_REL;
               end else begin
                  phase_q <= nxt_ph;
                  idx_q   <= '0;
                  state_q <= ST_ISSUE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   flash_seq_txsel #(.DATA_BYTES(DATA_BYTES)) u_txsel (
      .phase    (phase_q),
      .idx      (idx_q),
      .n_addr   (n_addr_q),
      .cmd      (cmd_q),
      .addr     (addr_q),
      .wdata    (wdata_q),
      .is_write (wr_q),
      .tx       (sh_tx)
   );

   assign capture = (state_q == ST_WAIT) && sh_done && (phase_q == PH_DATA) && !wr_q;

   flash_seq_rxpack #(.DATA_BYTES(DATA_BYTES), .IDX_W(CNT_W)) u_rxpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (capture),
      .idx     (idx_q),
      .rx      (sh_rx),
      .data    (rsp_rdata)
   );

   assign sel_on = (state_q == ST_SEL) || (state_q == ST_ISSUE) || (state_q == ST_WAIT);

   if (NUM_CS == 1) begin : g_single_cs
      assign cs_n[0] = !sel_on;
   end else begin : g_multi_cs
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign cs_n[c] = !(sel_on && cs_q == CS_IDX_W'(c));
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign rsp_valid = (state_q == ST_REL);
   assign sh_start  = (state_q == ST_ISSUE);
   assign conflict  = conflict_q;

endmodule

// File: rtl/flash_window_seq_chk.sv
module flash_window_seq_chk #(
   parameter int NUM_CS = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              busy,
   input logic              rsp_valid,
   input logic              conflict,
   input logic [NUM_CS-1:0] cs_n,
   input logic              sh_start,
   input logic [7:0]        sh_tx
);

   // R1
   idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> &cs_n);

   // R2
   single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R2
   accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy && !req_ready));

   // R6
   rsp_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> &cs_n);

   // R8
   conflict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |=> !conflict);

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_start |=> !sh_start);

   // R9
   start_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_start |-> !(&cs_n));

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_start |=> $stable(sh_tx));

endmodule

bind flash_window_seq flash_window_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .busy      (busy),
   .rsp_valid (rsp_valid),
   .conflict  (conflict),
   .cs_n      (cs_n),
   .sh_start  (sh_start),
   .sh_tx     (sh_tx)
);

// File: tb/flash_window_seq_test.sv
module flash_window_seq_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] rd_cfg = '0;
   logic [31:0] wr_cfg = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [0:0]  req_cs = '0;
   logic [26:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        busy;
   logic        user_cs_held = 1'b0;
   logic        conflict;
   logic [1:0]  cs_n;
   logic        sh_start;
   logic [7:0]  sh_tx;
   logic        sh_done = 1'b0;
   logic [7:0]  sh_rx = '0;

   int checks = 0;
   int errors = 0;
   int lat = 1;
   logic [1:0] exp_cs = 2'b11;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_window_seq uut (
      .clk(clk), .rst_n(rst_n), .rd_cfg(rd_cfg), .wr_cfg(wr_cfg),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_cs(req_cs), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .busy(busy), .user_cs_held(user_cs_held), .conflict(conflict),
      .cs_n(cs_n), .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done),
      .sh_rx(sh_rx)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mkcfg(input logic [7:0] cmd, input logic [1:0] asz,
                                         input logic [1:0] dbw, input logic [1:0] acc);
      logic [31:0] w;
      w = '0;
      w[7:0]   = cmd;
      w[9:8]   = acc;
      w[13:12] = dbw;
      w[17:16] = asz;
      return w;
   endfunction

   // Shift engine model and byte scoreboard monitor.
   initial begin : engine
      logic [7:0] bno;
      logic [7:0] rxb;
      bno = '0;
      forever begin
         @(negedge clk);
         sh_done = 1'b0;
         if (&cs_n) bno = '0;
         if (sh_start) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected byte", {56'b0, sh_tx}, 64'h0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(sh_tx == e && cs_n == exp_cs, t, {48'b0, cs_n, 6'b0, sh_tx}, {48'b0, exp_cs, 6'b0, e});
            end
            rxb = 8'h5A ^ bno;
            bno = bno + 8'd1;
            repeat (lat) @(negedge clk);
            sh_done = 1'b1;
            sh_rx   = rxb;
         end
      end
   end

   task automatic push(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   task automatic access(input bit wr, input int cs, input logic [26:0] addr, input int size,
                         input logic [63:0] wd, input bit held, input int lt);
      logic [31:0] cfg;
      logic [31:0] a32;
      int na, nd, ds;
      logic [63:0] er;
      cfg = wr ? wr_cfg : rd_cfg;
      a32 = {5'b0, addr};
      case (cfg[17:16])
         2'd0:    na = 3;
         2'd1:    na = 4;
         default: na = 0;
      endcase
      nd = wr ? 0 : ((int'(cfg[13:12]) * 8) >> cfg[9:8]);
      push(cfg[7:0], wr ? "R3 write command" : "R3 read command");
      for (int i = na - 1; i >= 0; i--) push(a32[8*i +: 8], "R4 address byte");
      for (int i = 0; i < nd; i++) push(8'h00, "R5 dummy byte");
      for (int i = 0; i < size; i++) push(wr ? wd[8*i +: 8] : 8'h00, wr ? "R7 write data" : "R6 read slot");
      ds = 1 + na + nd;
      er = '0;
      for (int i = 0; i < size; i++) er[8*i +: 8] = 8'h5A ^ 8'(ds + i);
      lat = lt;
      exp_cs = ~(2'b01 << cs);
      @(negedge clk);
      user_cs_held = held;
      req_valid = 1'b1;
      req_write = wr;
      req_cs    = 1'(cs);
      req_addr  = addr;
      req_size  = 4'(size);
      req_wdata = wd;
      chk(req_ready, "R2 ready before accept", {63'b0, req_ready}, 64'h1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && !req_ready && cs_n == exp_cs, "R2 select and stall",
          {60'b0, busy, req_ready, cs_n}, {60'b0, 2'b10, exp_cs});
      chk(conflict == held, "R8 conflict flag", {63'b0, conflict}, {63'b0, held});
      while (!rsp_valid) @(negedge clk);
      chk(&cs_n, "R6 released at response", {62'b0, cs_n}, 64'h3);
      if (!wr) chk(rsp_rdata == er, "R6 read data", rsp_rdata, er);
      chk(exp_q.size() == 0, "R9 byte count", 64'(exp_q.size()), 64'h0);
      @(negedge clk);
      user_cs_held = 1'b0;
      chk(!busy && req_ready && &cs_n && !rsp_valid, "R1 idle after access",
          {60'b0, busy, req_ready, cs_n}, {60'b0, 2'b01, 2'b11});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(&cs_n && !busy && req_ready && !rsp_valid && !sh_start, "R1 reset state",
          {59'b0, cs_n, busy, req_ready, sh_start}, {59'b0, 2'b11, 3'b010});
      rst_n = 1'b1;
      @(negedge clk);

      // R4 three-byte address, R5 eight dummies
      rd_cfg = mkcfg(8'h0B, 2'd0, 2'd1, 2'd0);
      access(1'b0, 0, 27'h0123457, 4, '0, 1'b0, 1);
      // R4 four-byte address, R5 two dummies, R6 full width
      rd_cfg = mkcfg(8'hEC, 2'd1, 2'd1, 2'd2);
      access(1'b0, 1, 27'h5ABCDE1, 8, '0, 1'b0, 2);
      // R4 no address, R5 no dummy
      rd_cfg = mkcfg(8'h9F, 2'd2, 2'd0, 2'd0);
      access(1'b0, 0, 27'h0000010, 1, '0, 1'b0, 1);
      // R7 write, R5 dummy fields ignored on writes
      wr_cfg = mkcfg(8'h02, 2'd0, 2'd3, 2'd0);
      access(1'b1, 1, 27'h0000103, 8, 64'h8877665544332211, 1'b0, 1);
      wr_cfg = mkcfg(8'h12, 2'd1, 2'd2, 2'd1);
      access(1'b1, 0, 27'h7FFFFFD, 3, 64'h00000000_00C0FFEE, 1'b0, 3);
      // R8 conflict while software select held, R5 twelve dummies
      rd_cfg = mkcfg(8'h6B, 2'd0, 2'd3, 2'd1);
      access(1'b0, 1, 27'h0ABCDEF, 2, '0, 1'b1, 1);
      // R4 code 3 sends no address, R5 (16>>3)=2 dummies
      rd_cfg = mkcfg(8'h3B, 2'd3, 2'd2, 2'd3);
      access(1'b0, 0, 27'h0000001, 5, '0, 1'b0, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule